// File: doc/BRIEF.md
# EDO DRAM Strobe Cycle Decoder

This block is the device side of an asynchronous, strobe-driven DRAM port, rebuilt as synchronous logic. It samples the row strobe, column strobe, write enable and output enable pins, all active low, together with a multiplexed address bus and a data input bus. From the order in which the strobe edges arrive it works out what kind of memory cycle the host is running. It then reads or writes a small internal storage array and decides when the data pins are driven.

Each classified event is reported on a 3-bit class code with a one-cycle valid pulse. A scoreboard can follow the host controller's cycle sequence cycle by cycle. Reads use extended-data-out behaviour: once a read column has been accessed, its data stays on the pins through column-strobe precharge. The data is withdrawn when output enable is released, when write enable falls, or when both strobes return high.

The strobe pins pass through two-flop synchronisers, and edges are detected on the synchronised levels. Address and data inputs are sampled in the same clock in which the matching synchronised edge is seen. The array is addressed by the low row and column bits of the latched addresses.

Top module: `edo_strobe_decoder`

## Requirements
- R1: After reset `dq_oe_o`, `cls_vld_o` and `self_ref_o` are 0, `ref_row_o` is 0 and every stored word is 0.
- R2: A row-strobe fall with the column strobe high latches the address as the row. A column-strobe fall with write enable high latches the column, raises `dq_oe_o` while output enable is low, and presents the word at {row low bits, column low bits} on `dq_o`. The following column-strobe rise pulses class code 1 (read).
- R3: If write enable is low when the column strobe falls, `dq_i` is stored at the addressed word and class code 3 (write) pulses. `dq_oe_o` stays 0 for the whole cycle.
- R4: After a read column access in which output enable was low, a write-enable fall while the column strobe is still low does three things: it stores `dq_i` at the same word, it pulses class code 4 (read-modify-write), and it drops `dq_oe_o`. Before that fall, `dq_o` shows the old word.
- R5: While the row strobe stays low, each further column-strobe fall latches a new column in the same row. Reads after the first in the same row cycle report class code 2 (page read) when the column strobe rises.
- R6: After a read column access, `dq_oe_o` and `dq_o` hold through column-strobe high while the row strobe is low. `dq_oe_o` falls when output enable rises, when write enable falls, or when both strobes are high.
- R7: A row-strobe pulse with no column-strobe fall inside it pulses class code 5 (row-only refresh). It leaves `dq_oe_o` at 0 and leaves stored words unchanged.
- R8: A row-strobe fall while the column strobe is already low pulses class code 6 (CBR refresh). It advances the 11-bit `ref_row_o` by one, modulo 2048.
- R9: If both strobes stay low for `SELF_REF_CYC` synchronised clocks after a CBR start, `self_ref_o` rises and class code 7 pulses. `self_ref_o` then holds whatever the column strobe does and clears only when the row strobe rises. If the column strobe rises before the count completes, the block does not enter self-refresh.
- R10: A write-enable fall while the column strobe is low after a read column access in which output enable stayed high stores `dq_i` and reports class code 3. Every class pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe pin, active low |
| cas_ni | input | 1 | Column strobe pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DATA_W | Write data from the pins |
| dq_o | output | DATA_W | Read data toward the pins |
| dq_oe_o | output | 1 | Data pin drive enable |
| cls_o | output | 3 | Cycle class code |
| cls_vld_o | output | 1 | One-cycle class valid pulse |
| self_ref_o | output | 1 | Self-refresh state |
| ref_row_o | output | 11 | Internal refresh row counter |

## Verification
The assertions assume that two strobe edges never land in the same synchronised clock. They also assume that address and data are stable from the strobe pin change until the synchronised edge has been acted on. The stimulus keeps to these assumptions by changing at most one group of pins at a time and then waiting four clocks before the next change or check. Random operations draw row, column and data values from a seeded generator. Directed sequences cover EDO release by output enable and by write enable, late write, and self-refresh, both entered and abandoned.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;
  typedef enum logic [2:0] {
    CLS_NONE      = 3'd0,
    CLS_READ      = 3'd1,
    CLS_PAGE_READ = 3'd2,
    CLS_WRITE     = 3'd3,
    CLS_RMW       = 3'd4,
    CLS_RAS_ONLY  = 3'd5,
    CLS_CBR       = 3'd6,
    CLS_SELF      = 3'd7
  } cyc_cls_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_CBR, ST_SELF} dec_st_e;
  typedef enum logic [1:0] {CK_NONE, CK_RD, CK_WR} col_kind_e;

  localparam int unsigned SIG_RAS = 0;
  localparam int unsigned SIG_CAS = 1;
  localparam int unsigned SIG_WE  = 2;
  localparam int unsigned SIG_OE  = 3;
  localparam int unsigned N_SIG   = 4;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
  parameter int unsigned N       = 4,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic ff1_q, ff2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q  <= RST_LVL;
        ff2_q  <= RST_LVL;
        prev_q <= RST_LVL;
      end else begin
        ff1_q  <= async_i[i];
        ff2_q  <= ff1_q;
        prev_q <= ff2_q;
      end
    end
    assign lvl_o[i]  = ff2_q;
    assign fall_o[i] = prev_q & ~ff2_q;
    assign rise_o[i] = ~prev_q & ff2_q;
  end
endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (step_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 3,
  parameter int unsigned DATA_W   = 4,
  localparam int unsigned IDX_W   = ROW_BITS + COL_BITS,
  localparam int unsigned DEPTH   = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (wr_en_i) begin
      cell_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = cell_q[rd_idx_i];
endmodule

// File: rtl/edo_cycle_fsm.sv
module edo_cycle_fsm
  import edo_dec_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned SELF_REF_CYC = 20000,
  localparam int unsigned CNT_W       = $clog2(SELF_REF_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SIG-1:0]  lvl_i,
  input  logic [N_SIG-1:0]  fall_i,
  input  logic [N_SIG-1:0]  rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [ADDR_W-1:0] wr_col_o,
  output logic              wr_en_o,
  output logic              data_vld_o,
  output logic              cbr_step_o,
  output cyc_cls_e          cls_o,
  output logic              cls_vld_o,
  output logic              self_ref_o
);
  dec_st_e     st_q, st_d;
  col_kind_e   ck_q, ck_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic        col_seen_q, col_seen_d, page_q, page_d;
  logic        oe_seen_q, oe_seen_d, armed_q, armed_d, dv_q, dv_d;
  cyc_cls_e    cls_q, cls_d;
  logic        vld_q, vld_d;

  logic ras_l, cas_l, we_l, oe_l;
  assign ras_l = lvl_i[SIG_RAS];
  assign cas_l = lvl_i[SIG_CAS];
  assign we_l  = lvl_i[SIG_WE];
  assign oe_l  = lvl_i[SIG_OE];

  always_comb begin
    st_d       = st_q;
    ck_d       = ck_q;
    row_d      = row_q;
    col_d      = col_q;
    cnt_d      = cnt_q;
    col_seen_d = col_seen_q;
    page_d     = page_q;
    oe_seen_d  = oe_seen_q;
    armed_d    = armed_q;
    dv_d       = dv_q;
    cls_d      = CLS_NONE;
    vld_d      = 1'b0;
    wr_en_o    = 1'b0;
    cbr_step_o = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (fall_i[SIG_RAS]) begin
          if (!cas_l) begin
            st_d       = ST_CBR;
            cls_d      = CLS_CBR;
            vld_d      = 1'b1;
            cbr_step_o = 1'b1;
            cnt_d      = '0;
            armed_d    = 1'b1;
          end else begin
            st_d       = ST_ROW;
            row_d      = addr_i;
            col_seen_d = 1'b0;
            ck_d       = CK_NONE;
          end
        end
      end
      ST_ROW: begin
        if (ck_q == CK_RD && !oe_l) oe_seen_d = 1'b1;
        if (rise_i[SIG_RAS]) begin
          st_d = ST_IDLE;
          ck_d = CK_NONE;
          if (ck_q == CK_RD) begin
            cls_d = page_q ? CLS_PAGE_READ : CLS_READ;
            vld_d = 1'b1;
          end else if (!col_seen_q) begin
            cls_d = CLS_RAS_ONLY;
            vld_d = 1'b1;
          end
        end else if (fall_i[SIG_CAS]) begin
          col_d      = addr_i;
          col_seen_d = 1'b1;
          page_d     = col_seen_q;
          if (!we_l) begin
            wr_en_o = 1'b1;
            ck_d    = CK_WR;
            dv_d    = 1'b0;
            cls_d   = CLS_WRITE;
            vld_d   = 1'b1;
          end else begin
            ck_d      = CK_RD;
            dv_d      = 1'b1;
            oe_seen_d = !oe_l;
          end
        end else if (rise_i[SIG_CAS]) begin
          if (ck_q == CK_RD) begin
            cls_d = page_q ? CLS_PAGE_READ : CLS_READ;
            vld_d = 1'b1;
          end
          ck_d = CK_NONE;
        end else if (fall_i[SIG_WE] && ck_q == CK_RD && !cas_l) begin
          wr_en_o = 1'b1;
          cls_d   = oe_seen_q ? CLS_RMW : CLS_WRITE;
          vld_d   = 1'b1;
          ck_d    = CK_NONE;
        end
      end
      ST_CBR: begin
        if (rise_i[SIG_RAS]) begin
          st_d = ST_IDLE;
        end else if (cas_l) begin
          armed_d = 1'b0;
        end else if (armed_q) begin
          if (cnt_q == CNT_W'(SELF_REF_CYC - 1)) begin
            st_d  = ST_SELF;
            cls_d = CLS_SELF;
            vld_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SELF: begin
        if (rise_i[SIG_RAS]) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    if (fall_i[SIG_WE]) dv_d = 1'b0;
    if (ras_l && cas_l) dv_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ck_q       <= CK_NONE;
      row_q      <= '0;
      col_q      <= '0;
      cnt_q      <= '0;
      col_seen_q <= 1'b0;
      page_q     <= 1'b0;
      oe_seen_q  <= 1'b0;
      armed_q    <= 1'b0;
      dv_q       <= 1'b0;
      cls_q      <= CLS_NONE;
      vld_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      ck_q       <= ck_d;
      row_q      <= row_d;
      col_q      <= col_d;
      cnt_q      <= cnt_d;
      col_seen_q <= col_seen_d;
      page_q     <= page_d;
      oe_seen_q  <= oe_seen_d;
      armed_q    <= armed_d;
      dv_q       <= dv_d;
      cls_q      <= cls_d;
      vld_q      <= vld_d;
    end
  end

  assign row_o      = row_q;
  assign col_o      = col_q;
  assign wr_col_o   = col_d;
  assign data_vld_o = dv_q;
  assign cls_o      = cls_q;
  assign cls_vld_o  = vld_q;
  assign self_ref_o = (st_q == ST_SELF);

  assert_cbr_cas_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_vld_o && cls_o == CLS_CBR) |-> $past(!cas_l));
  assert_self_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(self_ref_o) |-> $past(rise_i[SIG_RAS]));
  assert_pulse_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_vld_o |=> !cls_vld_o);
endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
  import edo_dec_pkg::*;
#(
  parameter int unsigned ADDR_W       = 11,
  parameter int unsigned DATA_W       = 4,
  parameter int unsigned ROW_BITS     = 3,
  parameter int unsigned COL_BITS     = 3,
  parameter int unsigned REF_W        = 11,
  parameter int unsigned SELF_REF_CYC = 20000,
  localparam int unsigned IDX_W       = ROW_BITS + COL_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [2:0]        cls_o,
  output logic              cls_vld_o,
  output logic              self_ref_o,
  output logic [REF_W-1:0]  ref_row_o
);
  logic [N_SIG-1:0]  pins, lvl, fall, rise;
  logic [ADDR_W-1:0] row, col, wr_col;
  logic              wr_en, data_vld, cbr_step;
  cyc_cls_e          cls;

  always_comb begin
    pins          = '1;
    pins[SIG_RAS] = ras_ni;
    pins[SIG_CAS] = cas_ni;
    pins[SIG_WE]  = we_ni;
    pins[SIG_OE]  = oe_ni;
  end

  edo_strobe_sync #(.N(N_SIG), .RST_LVL(1'b1)) u_sync (
    .clk_i, .rst_ni, .async_i(pins), .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  edo_cycle_fsm #(.ADDR_W(ADDR_W), .SELF_REF_CYC(SELF_REF_CYC)) u_fsm (
    .clk_i, .rst_ni, .lvl_i(lvl), .fall_i(fall), .rise_i(rise), .addr_i,
    .row_o(row), .col_o(col), .wr_col_o(wr_col), .wr_en_o(wr_en),
    .data_vld_o(data_vld), .cbr_step_o(cbr_step), .cls_o(cls),
    .cls_vld_o(cls_vld_o), .self_ref_o(self_ref_o)
  );

  edo_refresh_ctr #(.W(REF_W)) u_ref (
    .clk_i, .rst_ni, .step_i(cbr_step), .row_o(ref_row_o)
  );

  edo_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_arr (
    .clk_i, .rst_ni, .wr_en_i(wr_en),
    .wr_idx_i({row[ROW_BITS-1:0], wr_col[COL_BITS-1:0]}),
    .wr_data_i(dq_i),
    .rd_idx_i({row[ROW_BITS-1:0], col[COL_BITS-1:0]}),
    .rd_data_o(dq_o)
  );

  assign cls_o   = cls;
  assign dq_oe_o = data_vld & ~lvl[SIG_OE] & lvl[SIG_WE];

  assert_ref_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_vld_o && cls_o == CLS_CBR) |-> ref_row_o == $past(ref_row_o) + 1'b1);
  assert_write_hiz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_vld_o && cls_o == CLS_WRITE) |-> !dq_oe_o);
  assert_rasonly_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_vld_o && cls_o == CLS_RAS_ONLY) |-> !dq_oe_o);
  assert_self_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(self_ref_o) |-> (cls_vld_o && cls_o == CLS_SELF));
endmodule

// File: tb/sim_edo_strobe_decoder.sv
`timescale 1ns/1ps
module sim_edo_strobe_decoder;
  localparam int AW = 11, DW = 4, RB = 3, CB = 3, SRC = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic dq_oe, cls_vld, self_ref;
  logic [2:0] cls;
  logic [10:0] ref_row;

  always #2.5 clk = ~clk;

  edo_strobe_decoder #(.ADDR_W(AW), .DATA_W(DW), .ROW_BITS(RB), .COL_BITS(CB),
                       .SELF_REF_CYC(SRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .cls_o(cls), .cls_vld_o(cls_vld), .self_ref_o(self_ref), .ref_row_o(ref_row)
  );

  int n_chk = 0, n_bad = 0, n_cls = 0, cls_mark = 0;
  logic [2:0] last_cls = '0;
  logic [DW-1:0] model [64];
  logic [10:0] ref_exp = '0;

  always @(negedge clk) if (rst_n && cls_vld) begin
    n_cls++;
    last_cls = cls;
  end

  function automatic int idx(input logic [AW-1:0] r, input logic [AW-1:0] c);
    return int'({r[RB-1:0], c[CB-1:0]});
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(negedge clk);
  endtask

  task automatic exp_cls(input string tag, input logic [2:0] code);
    check({tag, " class"}, 32'(last_cls), 32'(code));
    check({tag, " pulse count"}, n_cls, cls_mark + 1);
    cls_mark = n_cls;
  endtask

  task automatic do_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
    addr = r; ras_n = 0; step();
    addr = c; oe_n = 0; cas_n = 0; step();
    check("R2 drive", 32'(dq_oe), 1);
    check("R2 data", 32'(dq_out), 32'(model[idx(r, c)]));
    cas_n = 1; step();
    exp_cls("R2 read", 3'd1);
    check("R6 edo hold drive", 32'(dq_oe), 1);
    check("R6 edo hold data", 32'(dq_out), 32'(model[idx(r, c)]));
    ras_n = 1; step();
    check("R6 release both high", 32'(dq_oe), 0);
    oe_n = 1; step();
  endtask

  task automatic do_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
    addr = r; ras_n = 0; step();
    addr = c; we_n = 0; dq_in = d; cas_n = 0; step();
    exp_cls("R3 early write", 3'd3);
    check("R3 hiz", 32'(dq_oe), 0);
    model[idx(r, c)] = d;
    cas_n = 1; step();
    check("R3 hiz after cas", 32'(dq_oe), 0);
    ras_n = 1; we_n = 1; step();
  endtask

  task automatic do_rmw(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
    addr = r; ras_n = 0; step();
    addr = c; oe_n = 0; cas_n = 0; step();
    check("R4 old data", 32'(dq_out), 32'(model[idx(r, c)]));
    check("R4 drive before", 32'(dq_oe), 1);
    dq_in = d; we_n = 0; step();
    exp_cls("R4 rmw", 3'd4);
    check("R4 release", 32'(dq_oe), 0);
    model[idx(r, c)] = d;
    cas_n = 1; we_n = 1; oe_n = 1; step();
    ras_n = 1; step();
  endtask

  task automatic do_page(input logic [AW-1:0] r, input logic [AW-1:0] c0, input int n);
    addr = r; ras_n = 0; step();
    oe_n = 0;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] c = c0 + AW'(k * 3);
      addr = c; cas_n = 0; step();
      check("R5 page data", 32'(dq_out), 32'(model[idx(r, c)]));
      cas_n = 1; step();
      exp_cls("R5 page class", (k == 0) ? 3'd1 : 3'd2);
      check("R6 edo page hold", 32'(dq_oe), 1);
    end
    ras_n = 1; oe_n = 1; step();
  endtask

  task automatic do_rasonly(input logic [AW-1:0] r);
    addr = r; ras_n = 0; oe_n = 0; step();
    check("R7 no drive", 32'(dq_oe), 0);
    ras_n = 1; step();
    exp_cls("R7 ras-only", 3'd5);
    oe_n = 1; step();
  endtask

  task automatic do_cbr();
    cas_n = 0; step();
    ras_n = 0; step();
    exp_cls("R8 cbr", 3'd6);
    ref_exp = ref_exp + 11'd1;
    check("R8 counter", 32'(ref_row), 32'(ref_exp));
    ras_n = 1; step();
    cas_n = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset oe", 32'(dq_oe), 0);
    check("R1 reset vld", 32'(cls_vld), 0);
    check("R1 reset self", 32'(self_ref), 0);
    check("R1 reset ref", 32'(ref_row), 0);
    rst_n = 1; step();
    do_read(11'd5, 11'd2);

    do_write(11'd3, 11'd4, 4'hA);
    do_read(11'd3, 11'd4);
    do_rmw(11'd3, 11'd4, 4'h5);
    do_read(11'd3, 11'd4);

    // R6 release by OE rise while CAS high
    addr = 11'd3; ras_n = 0; step();
    addr = 11'd4; oe_n = 0; cas_n = 0; step();
    cas_n = 1; step();
    exp_cls("R6 read", 3'd1);
    oe_n = 1; step();
    check("R6 release oe", 32'(dq_oe), 0);
    ras_n = 1; step();

    // R6 release by WE fall while CAS high
    addr = 11'd3; ras_n = 0; step();
    addr = 11'd4; oe_n = 0; cas_n = 0; step();
    cas_n = 1; step();
    exp_cls("R6 read", 3'd1);
    we_n = 0; step();
    check("R6 release we", 32'(dq_oe), 0);
    we_n = 1; step();
    check("R6 stays off", 32'(dq_oe), 0);
    ras_n = 1; oe_n = 1; step();

    // R10 late write with OE held high
    addr = 11'd6; ras_n = 0; step();
    addr = 11'd1; cas_n = 0; step();
    dq_in = 4'h9; we_n = 0; step();
    exp_cls("R10 late write", 3'd3);
    model[idx(11'd6, 11'd1)] = 4'h9;
    cas_n = 1; we_n = 1; step();
    check("R10 single pulse", n_cls, cls_mark);
    ras_n = 1; step();
    do_read(11'd6, 11'd1);

    do_rasonly(11'd6);
    do_read(11'd6, 11'd1);
    do_cbr();

    // R9 self-refresh entry, CAS independence, exit
    cas_n = 0; step();
    ras_n = 0; step();
    exp_cls("R9 cbr start", 3'd6);
    ref_exp = ref_exp + 11'd1;
    repeat (SRC + 8) @(negedge clk);
    check("R9 self on", 32'(self_ref), 1);
    exp_cls("R9 self class", 3'd7);
    cas_n = 1; step();
    check("R9 self holds", 32'(self_ref), 1);
    ras_n = 1; step();
    check("R9 self exit", 32'(self_ref), 0);

    // R9 abandoned entry
    cas_n = 0; step();
    ras_n = 0; step();
    exp_cls("R9 cbr start2", 3'd6);
    ref_exp = ref_exp + 11'd1;
    cas_n = 1;
    repeat (SRC + 8) @(negedge clk);
    check("R9 no entry", 32'(self_ref), 0);
    check("R9 no pulse", n_cls, cls_mark);
    ras_n = 1; step();
    check("R8 counter after self", 32'(ref_row), 32'(ref_exp));

    do_page(11'd2, 11'd0, 4);

    for (int t = 0; t < 150; t++) begin
      logic [AW-1:0] r = AW'($urandom);
      logic [AW-1:0] c = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      case ($urandom % 6)
        0: do_read(r, c);
        1: do_write(r, c, d);
        2: do_rmw(r, c, d);
        3: do_page(r, c, 1 + int'($urandom % 4));
        4: do_rasonly(r);
        default: do_cbr();
      endcase
    end

    for (int i = 0; i < 64; i++) do_read(AW'(i >> 3), AW'(i & 7));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule